// File: doc/BRIEF.md
# Digitally Filtered PLL Lock Detector

This block turns the edge timing of a phase-locked loop into a clean lock flag. Once per comparison cycle it measures how far apart the rising edges of the reference divider and the feedback divider are. It counts that distance in periods of a fast sampling clock. A hysteresis filter then decides whether the loop is locked.

The filter is deliberately asymmetric. Lock is granted only after a run of consecutive cycles with a small error, and it is withdrawn after a single cycle with a large error. An error that falls between the two limits restarts the run but does not disturb a lock that already exists. If one divider edge arrives and its partner does not appear within a timeout, the cycle counts as a large error.

A shared output pin carries one of several sources, chosen by a select field:
- the filtered lock;
- a simple status that follows charge-pump activity;
- a constant low;
- an auxiliary signal passed through from elsewhere.

Power-down forces both lock sources low. When power-down is released, the detector starts again from the unlocked state.

Top module: `pll_lock_filter`

## Requirements
- R1: The phase error of a cycle is the number of sampling-clock periods between the first and the second divider rising edge. Either divider may lead. Coincident edges give an error of 0.
- R2: A cycle is good when its error is below GOOD_LIMIT (default 4). After GOOD_RUN (default 5) consecutive good cycles the filtered lock goes high. After GOOD_RUN-1 such cycles it is still low.
- R3: A cycle is bad when its error is above BAD_LIMIT (default 8). One bad cycle clears the filtered lock and the good-cycle run.
- R4: A cycle with an error from GOOD_LIMIT to BAD_LIMIT inclusive leaves the filtered lock unchanged and restarts the good-cycle run from zero.
- R5: If one divider edge is not followed by the other divider's edge within TIMEOUT (default 32) sampling periods, the cycle is treated as bad.
- R6: The pump status goes low one sampling cycle after the charge-pump activity input is high. It goes high again at a reference-divider edge only when the whole window since the previous reference edge had no pump activity.
- R7: The pin select input sets the pin source: 2'b00 drives constant low, 2'b01 the filtered lock, 2'b10 the pump status, 2'b11 the auxiliary input.
- R8: While power-down is high, the filtered lock and the pump status read low on the pin. After release, lock needs a fresh run of GOOD_RUN good cycles.
- R9: After reset the filtered lock and the pump status are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_div_i | input | 1 | Reference divider output |
| fb_div_i | input | 1 | Feedback divider output |
| pump_active_i | input | 1 | High while the charge pump drives current |
| power_down_i | input | 1 | PLL power-down |
| pin_sel_i | input | 2 | Shared pin source select |
| aux_i | input | 1 | Auxiliary signal for the shared pin |
| pin_o | output | 1 | Shared output pin |

## Verification
The hardest state to reach from the ports is the middle band. There, a locked detector must hold its lock while its hidden good-cycle run is thrown away.

The stimulus first enters lock, then applies middle-band errors at both edges of the band and shows that the pin stays high. Starting unlocked, it then places one middle-band cycle inside a good run. It shows that the full GOOD_RUN count is needed again: one cycle fewer leaves the pin low. The timeout path is reached by giving only the reference edge in a comparison cycle.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic [1:0] {
        PIN_LOW      = 2'b00,
        PIN_FILTERED = 2'b01,
        PIN_PUMP     = 2'b10,
        PIN_AUX      = 2'b11
    } pin_sel_e;

    typedef enum logic [1:0] {
        ERR_GOOD = 2'b00,
        ERR_MID  = 2'b01,
        ERR_BAD  = 2'b10
    } err_class_e;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_WAIT = 1'b1
    } meter_st_e;

endpackage

// File: rtl/lockdet_edge_in.sv
module lockdet_edge_in #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic rise_o
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], raw_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/lockdet_err_meter.sv
module lockdet_err_meter
    import lockdet_pkg::*;
#(
    parameter int TIMEOUT = 32,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             ref_rise_i,
    input  logic             fb_rise_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] err_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    typedef struct packed {
        meter_st_e        st;
        logic             first_ref;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic [CNT_W-1:0] err;
        logic             tmo;
    } meter_t;

    meter_t d, q;
    logic other_edge, same_edge;

    always_comb begin
        d          = q;
        d.valid    = 1'b0;
        d.tmo      = 1'b0;
        other_edge = q.first_ref ? fb_rise_i  : ref_rise_i;
        same_edge  = q.first_ref ? ref_rise_i : fb_rise_i;
        if (clear_i) begin
            d.st  = MS_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                MS_IDLE: begin
                    if (ref_rise_i && fb_rise_i) begin
                        d.valid = 1'b1;
                        d.err   = '0;
                    end else if (ref_rise_i || fb_rise_i) begin
                        d.st        = MS_WAIT;
                        d.first_ref = ref_rise_i;
                        d.cnt       = CNT_W'(1);
                    end
                end
                MS_WAIT: begin
                    if (other_edge) begin
                        d.valid = 1'b1;
                        d.err   = q.cnt;
                        d.st    = MS_IDLE;
                        d.cnt   = '0;
                    end else if (same_edge) begin
                        d.valid = 1'b1;
                        d.tmo   = 1'b1;
                        d.err   = q.cnt;
                        d.cnt   = CNT_W'(1);
                    end else if (q.cnt == LIMIT) begin
                        d.valid = 1'b1;
                        d.tmo   = 1'b1;
                        d.err   = q.cnt;
                        d.st    = MS_IDLE;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = MS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: MS_IDLE, first_ref: 1'b0, cnt: '0, valid: 1'b0, err: '0, tmo: 1'b0};
        else         q <= d;
    end

    assign valid_o   = q.valid;
    assign err_o     = q.err;
    assign timeout_o = q.tmo;

    assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == MS_WAIT) |-> (q.cnt != '0 && q.cnt <= LIMIT));

    assert_timeout_fires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == MS_WAIT && !clear_i && q.cnt == LIMIT && !other_edge) |=> (valid_o && timeout_o));

    assert_coincident_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == MS_IDLE && !clear_i && ref_rise_i && fb_rise_i) |=> (valid_o && err_o == '0 && !timeout_o));

endmodule

// File: rtl/lockdet_hysteresis.sv
module lockdet_hysteresis
    import lockdet_pkg::*;
#(
    parameter int GOOD_LIMIT = 4,
    parameter int BAD_LIMIT  = 8,
    parameter int GOOD_RUN   = 5,
    parameter int CNT_W      = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] err_i,
    input  logic             timeout_i,
    output logic             lock_o
);
    localparam int               RUN_W   = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GOOD_RUN);
    localparam logic [CNT_W-1:0] GOOD_L  = CNT_W'(GOOD_LIMIT);
    localparam logic [CNT_W-1:0] BAD_L   = CNT_W'(BAD_LIMIT);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
    } hyst_t;

    hyst_t            d, q;
    err_class_e       cls;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        if (timeout_i || err_i > BAD_L) cls = ERR_BAD;
        else if (err_i < GOOD_L)        cls = ERR_GOOD;
        else                            cls = ERR_MID;

        run_inc = (q.run == RUN_MAX) ? q.run : q.run + 1'b1;
        d       = q;
        if (clear_i) begin
            d.run  = '0;
            d.lock = 1'b0;
        end else if (valid_i) begin
            unique case (cls)
                ERR_GOOD: begin
                    d.run = run_inc;
                    if (run_inc == RUN_MAX) d.lock = 1'b1;
                end
                ERR_MID: d.run = '0;
                default: begin
                    d.run  = '0;
                    d.lock = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{run: '0, lock: 1'b0};
        else         q <= d;
    end

    assign lock_o = q.lock;

    assert_bad_unlocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && cls == ERR_BAD) |=> !lock_o);

    assert_lock_needs_good_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_o) |-> $past(valid_i && cls == ERR_GOOD && !clear_i));

    assert_mid_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && cls == ERR_MID && !clear_i) |=> ($stable(lock_o) && q.run == '0));

    assert_clear_unlocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (!lock_o && q.run == '0));

    assert_run_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.run <= RUN_MAX);

endmodule

// File: rtl/lockdet_pump_status.sv
module lockdet_pump_status (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic ref_rise_i,
    input  logic pump_i,
    output logic status_o
);
    typedef struct packed {
        logic seen;
        logic status;
    } pump_t;

    pump_t d, q;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.seen   = 1'b0;
            d.status = 1'b0;
        end else if (pump_i) begin
            d.seen   = 1'b1;
            d.status = 1'b0;
        end else if (ref_rise_i) begin
            d.status = !q.seen;
            d.seen   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{seen: 1'b0, status: 1'b0};
        else         q <= d;
    end

    assign status_o = q.status;

    assert_pump_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pump_i |=> !status_o);

    assert_rise_at_ref_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o) |-> $past(ref_rise_i && !pump_i));

endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter
    import lockdet_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GOOD_LIMIT  = 4,
    parameter int BAD_LIMIT   = 8,
    parameter int GOOD_RUN    = 5,
    parameter int TIMEOUT     = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ref_div_i,
    input  logic       fb_div_i,
    input  logic       pump_active_i,
    input  logic       power_down_i,
    input  logic [1:0] pin_sel_i,
    input  logic       aux_i,
    output logic       pin_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic             ref_rise, fb_rise;
    logic             meas_valid, meas_tmo;
    logic [CNT_W-1:0] meas_err;
    logic             filt_lock, pump_status;
    pin_sel_e         sel;

    lockdet_edge_in #(.STAGES(SYNC_STAGES)) u_ref_in (
        .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ref_div_i), .rise_o(ref_rise));

    lockdet_edge_in #(.STAGES(SYNC_STAGES)) u_fb_in (
        .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(fb_div_i), .rise_o(fb_rise));

    lockdet_err_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(power_down_i),
        .ref_rise_i(ref_rise), .fb_rise_i(fb_rise),
        .valid_o(meas_valid), .err_o(meas_err), .timeout_o(meas_tmo));

    lockdet_hysteresis #(
        .GOOD_LIMIT(GOOD_LIMIT), .BAD_LIMIT(BAD_LIMIT),
        .GOOD_RUN(GOOD_RUN), .CNT_W(CNT_W)
    ) u_hyst (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(power_down_i),
        .valid_i(meas_valid), .err_i(meas_err), .timeout_i(meas_tmo),
        .lock_o(filt_lock));

    lockdet_pump_status u_pump (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(power_down_i),
        .ref_rise_i(ref_rise), .pump_i(pump_active_i), .status_o(pump_status));

    always_comb begin
        sel = pin_sel_e'(pin_sel_i);
        unique case (sel)
            PIN_FILTERED: pin_o = filt_lock   & ~power_down_i;
            PIN_PUMP:     pin_o = pump_status & ~power_down_i;
            PIN_AUX:      pin_o = aux_i;
            default:      pin_o = 1'b0;
        endcase
    end

    assert_release_unlocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(power_down_i) |-> (!filt_lock && !pump_status));

    assert_limits_ordered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        meas_valid |-> (GOOD_LIMIT <= BAD_LIMIT && BAD_LIMIT < TIMEOUT));

endmodule

// File: tb/sim_pll_lock_filter.sv
module sim_pll_lock_filter;
    import lockdet_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0, fb_div = 1'b0, pump = 1'b0, pd = 1'b0, aux = 1'b0;
    logic [1:0] sel = PIN_FILTERED;
    logic       pin;
    int         total = 0, fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    pll_lock_filter u0 (
        .clk_i(clk), .rst_ni(rst_n), .ref_div_i(ref_div), .fb_div_i(fb_div),
        .pump_active_i(pump), .power_down_i(pd), .pin_sel_i(sel),
        .aux_i(aux), .pin_o(pin));

    task automatic check(input logic exp, input string req);
        total++;
        if (pin !== exp) begin
            fails++;
            $display("FAIL %s: pin=%0b expected %0b", req, pin, exp);
        end
    endtask

    // One 40-cycle comparison cycle; second edge comes gap cycles after the first.
    task automatic comp_cycle(input int gap, input bit fb_first, input bit drop_second);
        @(negedge clk);
        if (fb_first) fb_div = 1'b1; else ref_div = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (i == gap && !drop_second) begin
                ref_div = 1'b1;
                fb_div  = 1'b1;
            end
            @(negedge clk);
        end
        ref_div = 1'b0;
        fb_div  = 1'b0;
        repeat (19) @(negedge clk);
    endtask

    task automatic goods(input int n);
        for (int i = 0; i < n; i++) comp_cycle(2, i[0], 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pd = 1'b0; pump = 1'b0; aux = 1'b0; sel = PIN_FILTERED;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        sel = PIN_FILTERED; #1 check(1'b0, "R9");
        sel = PIN_PUMP;     #1 check(1'b0, "R9");
        sel = PIN_FILTERED;
    endtask

    task automatic t_entry();
        do_reset();
        goods(4);
        check(1'b0, "R2");
        comp_cycle(0, 1'b0, 1'b0);
        check(1'b1, "R2");
        comp_cycle(3, 1'b1, 1'b0); // boundary good, feedback leading
        check(1'b1, "R1");
    endtask

    task automatic t_mid();
        do_reset();
        goods(5);
        comp_cycle(4, 1'b0, 1'b0);
        check(1'b1, "R4");
        comp_cycle(8, 1'b1, 1'b0);
        check(1'b1, "R4");
        do_reset();
        goods(3);
        comp_cycle(6, 1'b0, 1'b0);
        goods(4);
        check(1'b0, "R4");
        goods(1);
        check(1'b1, "R4");
    endtask

    task automatic t_bad();
        do_reset();
        goods(5);
        comp_cycle(9, 1'b0, 1'b0);
        check(1'b0, "R3");
        goods(4);
        check(1'b0, "R3");
        goods(1);
        comp_cycle(12, 1'b1, 1'b0);
        check(1'b0, "R1");
    endtask

    task automatic t_timeout();
        do_reset();
        goods(5);
        check(1'b1, "R5");
        comp_cycle(0, 1'b0, 1'b1);
        check(1'b0, "R5");
    endtask

    task automatic t_pump();
        do_reset();
        sel = PIN_PUMP;
        goods(2);
        check(1'b1, "R6");
        @(negedge clk);
        ref_div = 1'b1;
        repeat (10) @(negedge clk);
        pump = 1'b1;
        @(negedge clk);
        pump = 1'b0;
        @(negedge clk);
        check(1'b0, "R6");
        repeat (10) @(negedge clk);
        ref_div = 1'b0;
        repeat (17) @(negedge clk);
        comp_cycle(0, 1'b0, 1'b0);
        check(1'b0, "R6");
        comp_cycle(0, 1'b0, 1'b0);
        check(1'b1, "R6");
        sel = PIN_FILTERED;
    endtask

    task automatic t_sel();
        do_reset();
        goods(5);
        sel = PIN_LOW;      #1 check(1'b0, "R7");
        sel = PIN_AUX; aux = 1'b1; #1 check(1'b1, "R7");
        aux = 1'b0;         #1 check(1'b0, "R7");
        sel = PIN_FILTERED; #1 check(1'b1, "R7");
        sel = PIN_PUMP;     #1 check(1'b1, "R7");
        sel = PIN_FILTERED;
    endtask

    task automatic t_pd();
        do_reset();
        goods(5);
        pd = 1'b1;
        repeat (2) @(negedge clk);
        check(1'b0, "R8");
        sel = PIN_PUMP; #1 check(1'b0, "R8");
        sel = PIN_AUX; aux = 1'b1; #1 check(1'b1, "R8");
        sel = PIN_FILTERED; aux = 1'b0;
        goods(2);
        check(1'b0, "R8");
        pd = 1'b0;
        goods(4);
        check(1'b0, "R8");
        goods(1);
        check(1'b1, "R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_entry();
        t_mid();
        t_bad();
        t_timeout();
        t_pump();
        t_sel();
        t_pd();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule